// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Host with Register Bank

This block is a serial-peripheral-interface host that exchanges one byte at a time with an attached device. Software controls it through a small bank of 8-bit registers on a simple memory-mapped bus. These registers cover configuration, clock rate, status, data and a slave-select port. A write to the data register starts a full-duplex exchange of eight bits. The host drives the serial clock and the outgoing data line, and it samples the incoming line on the edges selected by the clock polarity and phase bits. When all eight bits have been shifted, the received byte can be read back through the same data register.

The serial clock rate comes from a baud register with two fields: a 3-bit prescaler and a 3-bit exponent. Status flags report completion, a write collision, and a mode fault. A mode fault means the slave-select pin was pulled low by another party while this block was acting as host. Each flag clears only when software reads the status register and then accesses the data register. Two interrupt lines follow the completion flag and the fault flag behind a shared enable bit.

The slave-select pin either follows a port-data bit or, in automatic mode, goes low for the duration of each exchange. The port-direction register sets which pins are driven. The register bus is a plain single-cycle strobe interface with no back-pressure: every access completes in the cycle it is presented, reads return data combinationally, and read side effects take place at the clock edge that ends the access.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset every register reads 0x00, both interrupt lines are low, all three pin output enables are low and the serial clock output is low.
- R2: A data-register (address 0x09) write starts an 8-bit full-duplex exchange if three conditions hold: control bit 6 (enable) is set, control bit 4 (host mode) is set, and no exchange is running. After the exchange, reading address 0x09 returns the byte received on the input line, and the attached device has received the written byte.
- R3: With P = baud[6:4] and E = baud[2:0] (baud at address 0x04), each serial-clock half period lasts (P+1)·2^E bus clocks. Status bit 7 (done) is visible 16 half periods after the clock edge that accepted the data write. Baud bits 7 and 3 always read as 0.
- R4: While no exchange is running, the serial clock output equals control bit 3 (polarity).
- R5: With control bit 2 (phase) at 0, the first bit is on the output line before the first clock edge, and both sides sample on leading edges. With phase at 1, data changes on leading edges and is sampled on trailing edges.
- R6: With control bit 0 set, bits leave and arrive least-significant first; otherwise most-significant first.
- R7: A data-register write while an exchange is running sets status bit 6 (collision) and does not disturb the byte being shifted.
- R8: A set status flag stays set when only the status register (0x05) is read, or when only the data register is accessed. It clears when a status read is followed by a data-register access. Accesses to other addresses in between do not cancel the pending clear.
- R9: Suppose enable and host mode are set, port-direction bit 3 is 0, and the slave-select input is low after a two-stage synchronizer. Then status bit 4 (fault) sets, control bit 4 clears, and any running exchange stops with the clock back at its idle level and no done flag.
- R10: The done interrupt equals control bit 7 AND status bit 7. The fault interrupt equals control bit 7 AND status bit 4.
- R11: If control bit 1 is 0, the slave-select output follows port-data bit 3 (address 0x0D). If it is 1, the output is low during an exchange and high otherwise. Port-direction (address 0x10) bits 3, 2 and 1 drive the output enables of slave select, serial clock and output data.
- R12: The control register (0x00), the second control register (0x01), port data and port direction read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| miso_i | input | 1 | Serial data from the attached device |
| ss_i | input | 1 | Slave-select pin level, sensed for faults |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the attached device |
| ss_o | output | 1 | Slave-select drive level |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_oe | output | 1 | Output data enable |
| ss_oe | output | 1 | Slave-select output enable |
| irq_done | output | 1 | Exchange-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
The hardest situations to reach from the ports are a collision and a fault that land while bits are still moving. The stimulus for a collision issues a second data write four cycles into an exchange, then checks that the attached-device model still received the first byte. For a fault, the stimulus makes slave select an input, starts an exchange, and pulls the sensed pin low a few cycles later. The bench then confirms that the clock settles idle, host mode drops, and no done flag appears however long it waits. A behavioural device model on the serial pins, driven per polarity, phase and bit order, supplies the independent expectation for every exchange.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_CTL1 = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_CTL2 = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_BAUD = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_STAT = 5'h05;
  localparam logic [ADDR_W-1:0] ADR_DATA = 5'h09;
  localparam logic [ADDR_W-1:0] ADR_PORT = 5'h0D;
  localparam logic [ADDR_W-1:0] ADR_DDIR = 5'h10;

  // status bit positions
  localparam int SR_DONE  = 7;
  localparam int SR_COLL  = 6;
  localparam int SR_FAULT = 4;

  // port / direction bit positions
  localparam int PIN_SS   = 3;
  localparam int PIN_SCK  = 2;
  localparam int PIN_MOSI = 1;

  // baud field placement
  localparam int BAUD_PRE_LSB = 4;
  localparam int BAUD_EXP_LSB = 0;

  typedef struct packed {
    logic irq_en;
    logic sys_en;
    logic spare;
    logic master;
    logic cpol;
    logic cpha;
    logic ss_auto;
    logic lsb_first;
  } ctl1_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_len;

  // half period in bus clocks: (pre+1) * 2^expo
  always_comb half_len = (CNT_W'(pre) + CNT_W'(1)) << expo;

  assign tick = run && (cnt_q == half_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [DW-1:0] load_byte,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sclk,
  output logic          mosi
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  logic          busy_q;
  logic          phase_q;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] rx_q;
  logic [DW-1:0] rx_in;
  logic          step;
  logic          sample_edge;
  logic          last_edge;

  assign step        = busy_q && tick;
  // even edges are leading edges; phase 0 samples there, phase 1 on odd ones
  assign sample_edge = (edge_q[0] == cpha);
  assign last_edge   = (edge_q == EW'(EDGES - 1));

  always_comb begin
    if (lsb_first) rx_in = {miso, rx_sr[DW-1:1]};
    else           rx_in = {rx_sr[DW-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_q    <= '0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_sr   <= load_byte;
      rx_sr   <= '0;
    end else if (step) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + EW'(1);
      if (sample_edge) begin
        rx_sr <= rx_in;
      end else if (edge_q != '0) begin
        if (lsb_first) tx_sr <= tx_sr >> 1;
        else           tx_sr <= tx_sr << 1;
      end
      if (last_edge) begin
        busy_q <= 1'b0;
        rx_q   <= sample_edge ? rx_in : rx_sr;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = step && last_edge && !abort;
  assign rx_byte = rx_q;
  assign sclk    = cpol ^ phase_q;
  assign mosi    = lsb_first ? tx_sr[0] : tx_sr[DW-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_host_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [REG_W-1:0]  eng_rx,
  input  logic              ss_in,
  output logic              eng_start,
  output logic              eng_abort,
  output logic              cfg_cpol,
  output logic              cfg_cpha,
  output logic              cfg_lsb,
  output logic              cfg_ss_auto,
  output logic              cfg_master,
  output logic              cfg_irq_en,
  output logic [PRE_W-1:0]  baud_pre,
  output logic [EXP_W-1:0]  baud_exp,
  output logic              port_ss,
  output logic [2:0]        pin_dir,
  output logic              flag_done,
  output logic              flag_coll,
  output logic              flag_fault,
  output logic              irq_done,
  output logic              irq_fault
);
  ctl1_t             ctl1_q;
  logic [REG_W-1:0]  ctl2_q;
  logic [REG_W-1:0]  port_q;
  logic [REG_W-1:0]  ddir_q;
  logic [PRE_W-1:0]  pre_q;
  logic [EXP_W-1:0]  exp_q;
  logic              done_q, coll_q, fault_q;
  logic              arm_q;
  logic [2:0]        snap_q;
  logic              ss_seen;

  logic wr_hit, rd_hit, data_acc, data_wr, active, fault_now;

  assign wr_hit   = bus_sel && bus_wr;
  assign rd_hit   = bus_sel && !bus_wr;
  assign data_acc = bus_sel && (bus_addr == ADR_DATA);
  assign data_wr  = wr_hit && (bus_addr == ADR_DATA);
  assign active   = ctl1_q.sys_en && ctl1_q.master;

  // slave-select sense synchronizer
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= ss_in;
      end
      assign ss_seen = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[SYNC_STAGES-2:0], ss_in};
      end
      assign ss_seen = s_q[SYNC_STAGES-1];
    end
  endgenerate

  assign fault_now = active && !ddir_q[PIN_SS] && !ss_seen;
  assign eng_start = data_wr && active && !eng_busy && !fault_now;
  assign eng_abort = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q  <= '0;
      ctl2_q  <= '0;
      port_q  <= '0;
      ddir_q  <= '0;
      pre_q   <= '0;
      exp_q   <= '0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      fault_q <= 1'b0;
      arm_q   <= 1'b0;
      snap_q  <= '0;
    end else begin
      if (wr_hit) begin
        unique case (bus_addr)
          ADR_CTL1: ctl1_q <= ctl1_t'(bus_wdata);
          ADR_CTL2: ctl2_q <= bus_wdata;
          ADR_BAUD: begin
            pre_q <= bus_wdata[BAUD_PRE_LSB +: PRE_W];
            exp_q <= bus_wdata[BAUD_EXP_LSB +: EXP_W];
          end
          ADR_PORT: port_q <= bus_wdata;
          ADR_DDIR: ddir_q <= bus_wdata;
          default: ;
        endcase
      end
      // two-step clear: a status read arms, a later data access clears
      if (rd_hit && bus_addr == ADR_STAT) begin
        arm_q  <= 1'b1;
        snap_q <= {done_q, coll_q, fault_q};
      end else if (data_acc && arm_q) begin
        arm_q <= 1'b0;
        if (snap_q[2]) done_q  <= 1'b0;
        if (snap_q[1]) coll_q  <= 1'b0;
        if (snap_q[0]) fault_q <= 1'b0;
      end
      if (eng_done)            done_q <= 1'b1;
      if (data_wr && eng_busy) coll_q <= 1'b1;
      if (fault_now) begin
        fault_q       <= 1'b1;
        ctl1_q.master <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CTL1: bus_rdata = REG_W'(ctl1_q);
      ADR_CTL2: bus_rdata = ctl2_q;
      ADR_BAUD: bus_rdata = (REG_W'(pre_q) << BAUD_PRE_LSB) | (REG_W'(exp_q) << BAUD_EXP_LSB);
      ADR_STAT: begin
        bus_rdata[SR_DONE]  = done_q;
        bus_rdata[SR_COLL]  = coll_q;
        bus_rdata[SR_FAULT] = fault_q;
      end
      ADR_DATA: bus_rdata = eng_rx;
      ADR_PORT: bus_rdata = port_q;
      ADR_DDIR: bus_rdata = ddir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign cfg_cpol    = ctl1_q.cpol;
  assign cfg_cpha    = ctl1_q.cpha;
  assign cfg_lsb     = ctl1_q.lsb_first;
  assign cfg_ss_auto = ctl1_q.ss_auto;
  assign cfg_master  = ctl1_q.master;
  assign cfg_irq_en  = ctl1_q.irq_en;
  assign baud_pre    = pre_q;
  assign baud_exp    = exp_q;
  assign port_ss     = port_q[PIN_SS];
  assign pin_dir     = {ddir_q[PIN_SS], ddir_q[PIN_SCK], ddir_q[PIN_MOSI]};
  assign flag_done   = done_q;
  assign flag_coll   = coll_q;
  assign flag_fault  = fault_q;
  assign irq_done    = ctl1_q.irq_en && done_q;
  assign irq_fault   = ctl1_q.irq_en && fault_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              miso_i,
  input  logic              ss_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_o,
  output logic              sclk_oe,
  output logic              mosi_oe,
  output logic              ss_oe,
  output logic              irq_done,
  output logic              irq_fault
);
  logic             eng_busy, eng_done, eng_start, eng_abort, tick;
  logic [REG_W-1:0] eng_rx;
  logic             cfg_cpol, cfg_cpha, cfg_lsb, cfg_ss_auto, cfg_master, cfg_irq_en;
  logic [PRE_W-1:0] baud_pre;
  logic [EXP_W-1:0] baud_exp;
  logic             port_ss;
  logic [2:0]       pin_dir;
  logic             flag_done, flag_coll, flag_fault;

  spi_reg_bank #(
    .PRE_W(PRE_W), .EXP_W(EXP_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx), .ss_in(ss_i),
    .eng_start(eng_start), .eng_abort(eng_abort),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb(cfg_lsb),
    .cfg_ss_auto(cfg_ss_auto), .cfg_master(cfg_master), .cfg_irq_en(cfg_irq_en),
    .baud_pre(baud_pre), .baud_exp(baud_exp),
    .port_ss(port_ss), .pin_dir(pin_dir),
    .flag_done(flag_done), .flag_coll(flag_coll), .flag_fault(flag_fault),
    .irq_done(irq_done), .irq_fault(irq_fault)
  );

  spi_baud_gen #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .pre(baud_pre), .expo(baud_exp), .tick(tick)
  );

  spi_shift_engine #(.DW(REG_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .abort(eng_abort),
    .load_byte(bus_wdata), .cpol(cfg_cpol), .cpha(cfg_cpha), .lsb_first(cfg_lsb),
    .tick(tick), .miso(miso_i), .busy(eng_busy), .done(eng_done),
    .rx_byte(eng_rx), .sclk(sclk_o), .mosi(mosi_o)
  );

  assign ss_o    = cfg_ss_auto ? !eng_busy : port_ss;
  assign ss_oe   = pin_dir[2];
  assign sclk_oe = pin_dir[1];
  assign mosi_oe = pin_dir[0];
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk
  import spi_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              spif,
  input logic              wcol,
  input logic              modf,
  input logic              master,
  input logic              cpol,
  input logic              irq_en,
  input logic              sclk_o,
  input logic              irq_done,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);
  logic data_wr;
  assign data_wr = bus_sel && bus_wr && (bus_addr == ADR_DATA);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o == cpol));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (irq_en && spif));

  // R7
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol);

  // R9
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !master);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(busy));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .spif(flag_done),
  .wcol(flag_coll), .modf(flag_fault), .master(cfg_master), .cpol(cfg_cpol),
  .irq_en(cfg_irq_en), .sclk_o(sclk_o), .irq_done(irq_done),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
  import spi_host_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic miso_i, ss_i = 1'b1;
  logic sclk_o, mosi_o, ss_o, sclk_oe, mosi_oe, ss_oe, irq_done, irq_fault;

  always #2.5 clk = ~clk;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .miso_i(miso_i), .ss_i(ss_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .ss_o(ss_o), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .ss_oe(ss_oe),
    .irq_done(irq_done), .irq_fault(irq_fault)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- attached-device model ----------------
  bit m_cpol, m_cpha, m_lsb;
  bit sl_arm = 0;
  logic [7:0] sl_seed = '0;
  int sl_gen = 0;
  int sl_gen_seen = 0, sl_fin_gen = 0, sl_edges = 0;
  logic [7:0] sl_tx = '0, sl_rx = '0;

  assign miso_i = m_lsb ? sl_tx[0] : sl_tx[7];

  always @(sclk_o or sl_gen) begin
    if (sl_gen != sl_gen_seen) begin
      sl_gen_seen = sl_gen;
      sl_tx = sl_seed;
      sl_rx = '0;
      sl_edges = 0;
    end else if (sl_arm && sl_edges < 16) begin
      if ((sclk_o != m_cpol) ^ m_cpha) begin
        sl_rx = m_lsb ? {mosi_o, sl_rx[7:1]} : {sl_rx[6:0], mosi_o};
      end else if (sl_edges != 0) begin
        sl_tx = m_lsb ? (sl_tx >> 1) : (sl_tx << 1);
      end
      sl_edges++;
      if (sl_edges == 16) sl_fin_gen = sl_gen;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int mon_gen = 0;

  always @(negedge clk) begin
    if (sl_fin_gen != mon_gen) begin
      mon_gen = sl_fin_gen;
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected exchange", sl_rx, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(sl_rx == e, t, sl_rx, e);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    bus_read(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic prime(input logic [7:0] ctl, input logic [7:0] mtx, input logic [7:0] stx,
                       input string tag);
    m_cpol = ctl[3]; m_cpha = ctl[2]; m_lsb = ctl[0];
    sl_seed = stx;
    sl_gen++;
    sl_arm = 1;
    exp_q.push_back(mtx);
    tag_q.push_back(tag);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_xfer(input logic [7:0] ctl, input logic [7:0] mtx, input logic [7:0] stx,
                          input int cycles, input string tag);
    int n;
    prime(ctl, mtx, stx, tag);
    bus_write(ADR_DATA, mtx);
    wait_irq(n);
    check(n == cycles, "R3 exchange length", n, cycles);
    expect_reg(ADR_STAT, 8'h80, "R2 done flag");
    expect_reg(ADR_DATA, stx, tag);
    expect_reg(ADR_STAT, 8'h00, "R8 flag cleared");
    sl_arm = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n, hits;
    logic [7:0] v;
    m_cpol = 0; m_cpha = 0; m_lsb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(sclk_o == 0, "R1 sclk idle", sclk_o, 0);
    check({irq_done, irq_fault} == 0, "R1 irqs", {irq_done, irq_fault}, 0);
    check({ss_oe, sclk_oe, mosi_oe} == 0, "R1 enables", {ss_oe, sclk_oe, mosi_oe}, 0);
    expect_reg(ADR_STAT, 8'h00, "R1 status");
    expect_reg(ADR_CTL1, 8'h00, "R1 ctl1");
    expect_reg(ADR_BAUD, 8'h00, "R1 baud");

    // R11 / R12 pins and readback
    bus_write(ADR_DDIR, 8'h0E);
    bus_write(ADR_PORT, 8'h08);
    check({ss_oe, sclk_oe, mosi_oe} == 3'b111, "R11 enables", {ss_oe, sclk_oe, mosi_oe}, 7);
    check(ss_o == 1, "R11 ss follows port", ss_o, 1);
    bus_write(ADR_PORT, 8'h00);
    check(ss_o == 0, "R11 ss follows port low", ss_o, 0);
    expect_reg(ADR_PORT, 8'h00, "R12 port");
    expect_reg(ADR_DDIR, 8'h0E, "R12 ddir");
    bus_write(ADR_CTL2, 8'h5A);
    expect_reg(ADR_CTL2, 8'h5A, "R12 ctl2");
    bus_write(ADR_BAUD, 8'hFF);
    expect_reg(ADR_BAUD, 8'h77, "R3 baud mask");
    bus_write(ADR_BAUD, 8'h00);

    // R2 / R5 modes, R6 bit order
    bus_write(ADR_CTL1, 8'hD0);
    expect_reg(ADR_CTL1, 8'hD0, "R12 ctl1");
    run_xfer(8'hD0, 8'hA5, 8'h3C, 16, "R2 mode0");
    bus_write(ADR_CTL1, 8'hD4);
    run_xfer(8'hD4, 8'h96, 8'hE1, 16, "R5 phase1");
    bus_write(ADR_CTL1, 8'hD8);
    @(negedge clk);
    check(sclk_o == 1, "R4 idle high", sclk_o, 1);
    run_xfer(8'hD8, 8'h5B, 8'hC2, 16, "R5 pol1 phase0");
    bus_write(ADR_CTL1, 8'hDC);
    run_xfer(8'hDC, 8'h0F, 8'hF0, 16, "R5 pol1 phase1");
    bus_write(ADR_CTL1, 8'hD5);
    run_xfer(8'hD5, 8'h13, 8'hC8, 16, "R6 lsb first");
    bus_write(ADR_CTL1, 8'hD0);
    check(sclk_o == 0, "R4 idle low", sclk_o, 0);

    // R3 slower rate: P=2, E=1 -> half period 6
    bus_write(ADR_BAUD, 8'h21);
    run_xfer(8'hD0, 8'h6D, 8'h2B, 96, "R3 slow rate");
    bus_write(ADR_BAUD, 8'h00);

    // R7 write collision
    prime(8'hD0, 8'hA5, 8'h5E, "R7 byte undisturbed");
    bus_write(ADR_DATA, 8'hA5);
    repeat (3) @(negedge clk);
    bus_write(ADR_DATA, 8'h3C);
    wait_irq(n);
    expect_reg(ADR_STAT, 8'hC0, "R7 collision flag");
    expect_reg(ADR_DATA, 8'h5E, "R7 rx");
    expect_reg(ADR_STAT, 8'h00, "R8 both cleared");
    sl_arm = 0;

    // R8 clear sequence
    prime(8'hD0, 8'h71, 8'h8E, "R2 seq byte");
    bus_write(ADR_DATA, 8'h71);
    wait_irq(n);
    expect_reg(ADR_DATA, 8'h8E, "R2 rx");
    expect_reg(ADR_STAT, 8'h80, "R8 data alone keeps");
    expect_reg(ADR_CTL2, 8'h5A, "R12 ctl2 again");
    expect_reg(ADR_STAT, 8'h80, "R8 status alone keeps");
    expect_reg(ADR_DATA, 8'h8E, "R8 data read");
    expect_reg(ADR_STAT, 8'h00, "R8 cleared");
    sl_arm = 0;

    // R10 interrupt gating
    bus_write(ADR_CTL1, 8'h50);
    prime(8'h50, 8'hC3, 8'h3A, "R10 byte");
    bus_write(ADR_DATA, 8'hC3);
    hits = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (irq_done) hits++;
    end
    check(hits == 0, "R10 irq masked", hits, 0);
    expect_reg(ADR_STAT, 8'h80, "R10 flag still set");
    expect_reg(ADR_DATA, 8'h3A, "R10 rx");
    sl_arm = 0;

    // R11 automatic slave select
    bus_write(ADR_PORT, 8'h08);
    bus_write(ADR_CTL1, 8'hD2);
    @(negedge clk);
    check(ss_o == 1, "R11 auto idle", ss_o, 1);
    prime(8'hD2, 8'h2D, 8'hB4, "R11 byte");
    bus_write(ADR_DATA, 8'h2D);
    repeat (3) @(negedge clk);
    check(ss_o == 0, "R11 auto active", ss_o, 0);
    wait_irq(n);
    check(ss_o == 1, "R11 auto release", ss_o, 1);
    expect_reg(ADR_STAT, 8'h80, "R2 done");
    expect_reg(ADR_DATA, 8'hB4, "R11 rx");
    sl_arm = 0;

    // R9 mode fault mid exchange
    bus_write(ADR_DDIR, 8'h06);
    bus_write(ADR_CTL1, 8'hD0);
    bus_write(ADR_DATA, 8'h99);
    repeat (2) @(negedge clk);
    ss_i = 0;
    repeat (6) @(negedge clk);
    check(irq_fault == 1, "R10 fault irq", irq_fault, 1);
    check(sclk_o == 0, "R9 clock idle", sclk_o, 0);
    ss_i = 1;
    repeat (30) @(negedge clk);
    expect_reg(ADR_CTL1, 8'hC0, "R9 host mode dropped");
    expect_reg(ADR_STAT, 8'h10, "R9 fault only");
    expect_reg(ADR_DATA, 8'h8E & 8'h00 | 8'hB4, "R9 rx unchanged");
    expect_reg(ADR_STAT, 8'h00, "R8 fault cleared");
    check(irq_fault == 0, "R10 fault irq low", irq_fault, 0);

    check(exp_q.size() == 0, "R2 all exchanges seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule